// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block lets a clocked host reach a 32K x 8 asynchronous static RAM. The host offers one read or one write at a time through a valid/ready handshake. The controller then drives the memory's address and its three active-low strobes: chip select, write enable and output enable. It also drives its own half of the shared data bus. A read ends with a one-cycle done pulse, and the captured byte is held on the read-data port. The memory's intervals are parameters in nanoseconds, and each is turned into a whole number of clock cycles, rounded up. Changing the clock period or the speed grade therefore only means changing the parameters.

A write selects the chip one cycle before write enable falls. Output enable stays high for the whole write, so the memory never drives the bus while the controller does. The controller drives the bus from the falling edge of write enable until one cycle after it rises. Both strobes rise together, which is the moment the memory latches the data. A read holds select and output enable low for the access time and samples the bus on the last clock edge before the strobes are released. The data bus is split into output, output-enable and input ports; the pad cell or bench joins them into one tri-state bus.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, chip select, write enable and output enable are high, the bus driver is off, done is low and ready is high.
- R2: A request is accepted only when ready is high. Ready is high only while no access is running and at least ceil(TCYC_NS/CLK_NS) cycles have passed since the previous accept.
- R3: In a write, chip select falls one cycle before write enable. Write enable stays low for exactly max(1, ceil(max(TWP_NS, TDS_NS, TAW_NS-CLK_NS)/CLK_NS)) cycles, then rises together with chip select.
- R4: Output enable is high in every cycle in which write enable is low, and it is never low while the controller drives the bus.
- R5: The bus driver is on only while write enable is low and for the one cycle after it rises. The written byte stays unchanged in that window.
- R6: The memory address does not change while chip select is low, nor in the cycle in which chip select rises.
- R7: In a read, chip select and output enable are low and write enable is high for exactly ceil(TAA_NS/CLK_NS) cycles. The bus is sampled on the last edge of that window, and done is high for one cycle right after it.
- R8: The read-data port, while done is high, equals the byte most recently written to that address.
- R9: With no request, the strobes stay high and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Byte to write |
| rsp_done | output | 1 | One-cycle pulse: read data is valid |
| rsp_rdata | output | DW | Byte returned by the last read |
| mem_addr | output | AW | Address pins of the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DW | Byte the controller drives onto the bus |
| mem_dq_oe | output | 1 | Controller bus driver enable |
| mem_dq_in | input | DW | Byte seen on the bus |

## Verification
Some rules hold in every cycle and are checked by bound properties on each one. These are: no bus contention, output enable high while write enable is low, the driver window around write enable, address stability while selected, select leading write enable, ready only while deselected, and a done pulse one cycle wide. Other properties depend on timing counted in nanoseconds, and only the bench's memory model can show them. These are: the pulse width, data setup and address setup, the read access window against the access time, the spacing of accepts, and the byte returned after a mix of random and directed writes and reads.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } acc_state_e;

    // Interval in ns to clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_spacing_timer.sv
module sram_spacing_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic elapsed
);
    localparam int unsigned SW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [SW-1:0] LIM = SW'(LIMIT);

    logic [SW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = SW'(1);
        end else if (cnt_q < LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LIM;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign elapsed = (cnt_q >= LIM);
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW      = 15,
    parameter int unsigned DW      = 8,
    parameter int unsigned CLK_NS  = 20,
    parameter int unsigned TWP_NS  = 50,
    parameter int unsigned TDS_NS  = 30,
    parameter int unsigned TAW_NS  = 65,
    parameter int unsigned TAA_NS  = 70,
    parameter int unsigned TCYC_NS = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    // Address is set one cycle before the pulse, so that cycle counts toward address setup.
    localparam int unsigned TAW_REM = (TAW_NS > CLK_NS) ? (TAW_NS - CLK_NS) : 0;
    localparam int unsigned WP_NS   = umax(umax(TWP_NS, TDS_NS), TAW_REM);
    localparam int unsigned WP_CYC  = ns_to_cyc(WP_NS, CLK_NS);
    localparam int unsigned TAA_CYC = ns_to_cyc(TAA_NS, CLK_NS);
    localparam int unsigned TCYC_CYC = ns_to_cyc(TCYC_NS, CLK_NS);
    localparam int unsigned PW      = $clog2(umax(WP_CYC, TAA_CYC) + 1);

    typedef struct packed {
        acc_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          cs_n;
        logic          we_n;
        logic          oe_n;
        logic          dq_oe;
        logic          done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:    ST_IDLE,
        addr:  '0,
        wdata: '0,
        rdata: '0,
        cs_n:  1'b1,
        we_n:  1'b1,
        oe_n:  1'b1,
        dq_oe: 1'b0,
        done:  1'b0
    };

    ctl_t          ctl_d, ctl_q;
    logic          ph_load;
    logic [PW-1:0] ph_val;
    logic          ph_expired;
    logic          gap_start;
    logic          gap_elapsed;

    sram_phase_timer #(.W(PW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    sram_spacing_timer #(.LIMIT(TCYC_CYC)) u_spacing (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (gap_start),
        .elapsed (gap_elapsed)
    );

    assign req_ready = (ctl_q.st == ST_IDLE) && gap_elapsed;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        ph_load   = 1'b0;
        ph_val    = '0;
        gap_start = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && req_ready) begin
                    gap_start   = 1'b1;
                    ctl_d.addr  = req_addr;
                    ctl_d.cs_n  = 1'b0;
                    if (req_write) begin
                        ctl_d.st    = ST_WR_SETUP;
                        ctl_d.wdata = req_wdata;
                    end else begin
                        ctl_d.st   = ST_RD_ACCESS;
                        ctl_d.oe_n = 1'b0;
                        ph_load    = 1'b1;
                        ph_val     = PW'(TAA_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                ctl_d.st    = ST_WR_PULSE;
                ctl_d.we_n  = 1'b0;
                ctl_d.dq_oe = 1'b1;
                ph_load     = 1'b1;
                ph_val      = PW'(WP_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (ph_expired) begin
                    ctl_d.st   = ST_WR_RECOVER;
                    ctl_d.we_n = 1'b1;
                    ctl_d.cs_n = 1'b1;
                end
            end
            ST_WR_RECOVER: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.dq_oe = 1'b0;
            end
            ST_RD_ACCESS: begin
                if (ph_expired) begin
                    ctl_d.st    = ST_RD_DONE;
                    ctl_d.rdata = mem_dq_in;
                    ctl_d.done  = 1'b1;
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                end
            end
            ST_RD_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_done   = ctl_q.done;
    assign rsp_rdata  = ctl_q.rdata;
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_cs_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    // R4
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

    // R5
    wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mem_cs_n)) |-> $stable(mem_addr));

    // R3
    cs_leads_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_cs_n));

    // R2
    ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.AW(AW), .DW(DW)) u_strobe_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;
    localparam int CLK_NS  = 20;
    localparam int TWP_NS  = 50;
    localparam int TDS_NS  = 30;
    localparam int TAW_NS  = 65;
    localparam int TAA_NS  = 70;
    localparam int TCYC_NS = 70;

    function automatic int up_cyc(int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int exp_wp_cyc();
        int m;
        m = TWP_NS;
        if (TDS_NS > m) m = TDS_NS;
        if (TAW_NS - CLK_NS > m) m = TAW_NS - CLK_NS;
        return up_cyc(m);
    endfunction

    function automatic logic [7:0] init_byte(logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = 8'h00;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_accept = -1000;

    logic [7:0] store [logic [14:0]];
    logic [7:0] ref_mem [logic [14:0]];

    always #(CLK_NS/2) clk = ~clk;

    sram_strobe_ctrl #(
        .CLK_NS(CLK_NS), .TWP_NS(TWP_NS), .TDS_NS(TDS_NS),
        .TAW_NS(TAW_NS), .TAA_NS(TAA_NS), .TCYC_NS(TCYC_NS)
    ) i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic check(bit ok, string req, int act, int expv, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            check(1'b0, "watchdog", cyc, 0, "run did not end");
            finish_run();
        end
    end

    // Behavioural memory with timing checks, evaluated at falling edges.
    bit          p_wr, p_rd, p_cs;
    logic [14:0] p_addr;
    logic [7:0]  p_dq;
    int          wlow_n, cslow_n, dq_st_n, rd_n;

    always @(negedge clk) begin
        bit wr, rd;
        logic [7:0] v;
        if (!rst_n) begin
            p_wr = 0; p_rd = 0; p_cs = 0; wlow_n = 0; cslow_n = 0;
            dq_st_n = 0; rd_n = 0; p_dq = '0; p_addr = '0;
        end else begin
            wr = !mem_cs_n && !mem_we_n;
            rd = !mem_cs_n && !mem_oe_n && mem_we_n;
            if (wr) begin
                wlow_n++;
                if (!mem_oe_n) check(1'b0, "R4", 0, 1, "oe_n low during write");
                if (!mem_dq_oe) check(1'b0, "R5", 0, 1, "bus not driven in write");
            end
            if (mem_dq_oe && (dq_st_n == 0 || mem_dq_out == p_dq)) dq_st_n++;
            else if (mem_dq_oe) dq_st_n = 1;
            else dq_st_n = 0;
            if (p_wr && !wr) begin
                store[p_addr] = p_dq;
                check(wlow_n * CLK_NS >= TWP_NS, "R3", wlow_n * CLK_NS, TWP_NS, "write pulse ns");
                check((dq_st_n - 1) * CLK_NS >= TDS_NS, "R3", (dq_st_n - 1) * CLK_NS, TDS_NS, "data setup ns");
                check(cslow_n * CLK_NS >= TAW_NS, "R3", cslow_n * CLK_NS, TAW_NS, "addr setup ns");
                check(mem_dq_oe && mem_dq_out == p_dq, "R5", mem_dq_out, p_dq, "data hold after strobe");
                wlow_n = 0;
            end
            if (rd && p_rd && mem_addr == p_addr) rd_n++;
            else if (rd) rd_n = 1;
            else rd_n = 0;
            if (rd && mem_dq_oe) check(1'b0, "R4", 1, 0, "bus contention");
            if (!mem_cs_n && p_cs && mem_addr != p_addr)
                check(1'b0, "R6", mem_addr, p_addr, "address moved while selected");
            if (mem_cs_n && p_cs && mem_addr != p_addr)
                check(1'b0, "R6", mem_addr, p_addr, "address moved as select rose");
            v = store.exists(mem_addr) ? store[mem_addr] : init_byte(mem_addr);
            mem_dq_in = (rd && rd_n * CLK_NS - CLK_NS/2 >= TAA_NS) ? v : ~v;
            if (!mem_cs_n) cslow_n++; else cslow_n = 0;
            p_wr = wr; p_rd = rd; p_cs = !mem_cs_n; p_addr = mem_addr; p_dq = mem_dq_out;
        end
    end

    function automatic logic [7:0] ref_read(logic [14:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
    endfunction

    // Called at a falling edge; returns at a falling edge with the access finished.
    task automatic do_op(bit wr, logic [14:0] a, logic [7:0] d);
        int lat, wl;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        check(cyc - last_accept >= up_cyc(TCYC_NS), "R2", cyc - last_accept, up_cyc(TCYC_NS), "accept spacing");
        last_accept = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            wl = 0;
            for (int i = 0; i < exp_wp_cyc() + 4; i++) begin
                if (!mem_we_n) wl++;
                if (!mem_cs_n && req_ready) check(1'b0, "R2", 1, 0, "ready during write");
                @(negedge clk);
            end
            check(wl == exp_wp_cyc(), "R3", wl, exp_wp_cyc(), "write enable low cycles");
            ref_mem[a] = d;
        end else begin
            lat = 1;
            while (!rsp_done && lat < 20) begin
                if (req_ready) check(1'b0, "R2", 1, 0, "ready during read");
                @(negedge clk);
                lat++;
            end
            check(lat == up_cyc(TAA_NS) + 1, "R7", lat, up_cyc(TAA_NS) + 1, "done latency");
            check(rsp_rdata == ref_read(a), "R8", rsp_rdata, ref_read(a), "read data");
            @(negedge clk);
            check(!rsp_done, "R7", rsp_done, 0, "done width");
        end
    endtask

    initial begin
        int unsigned r;
        logic [14:0] a;
        r = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111, "strobes in reset");
        check(!mem_dq_oe && !rsp_done, "R1", {mem_dq_oe, rsp_done}, 0, "driver and done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1", req_ready, 1, "ready after reset");
        // R9 idle without requests
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R9",
                  {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110, "idle pins");
        end
        // Directed corners
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b1, 15'h0000, 8'hFF);
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b1, 15'h7FFF, 8'h00);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b1, 15'h0155, 8'hA5);
        do_op(1'b1, 15'h0155, 8'h5A);
        do_op(1'b0, 15'h0155, 8'h00);
        // Random mix over a small hot window plus the full range
        for (int n = 0; n < 400; n++) begin
            r = $urandom;
            a = (r[3:0] == 4'd0) ? 15'($urandom) : {10'd0, r[8:4]};
            do_op(r[12], a, 8'(r >> 16));
        end
        repeat (3) @(negedge clk);
        check(mem_cs_n && !mem_dq_oe, "R9", {mem_cs_n, mem_dq_oe}, 2'b10, "idle after traffic");
        finish_run();
    end
endmodule